// File: doc/BRIEF.md
# Snooping Cache Line Coherency Controller

This block holds the coherency state of every line in a small direct-indexed cache and updates it as operations arrive from the local processor and from bus snoops. Tag comparison and data storage live elsewhere. The block receives a line index, a hit flag and an operation code. It returns the line's next state and, when the bus has to act before the change is legal, a copyback request or a system-invalidate request.

Only one operation is serviced per cycle. If a snoop and a processor operation arrive together, the snoop goes first. When a bus action is needed, the update is held until the bus reports completion. No new operation is accepted while that update is waiting. The operating model (three-state or four-state) and the update policy (write-back or write-through) are quasi-static inputs. A lookup port returns the stored state of any line.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line reads as invalid on `look_state`, and no bus request is raised. The state codes are 00 invalid, 01 shared-clean, 10 exclusive-clean and 11 modified.
- R2: A read-miss fill (`cpu_op`=0) makes the line shared-clean if `shd` or `shd_late` is high, or if the three-state model or write-through is selected. Otherwise it makes the line exclusive-clean.
- R3: An intent-to-modify fill (`cpu_op`=2) always makes the line modified. A write-miss fill (`cpu_op`=1) makes it modified under write-back and leaves it unchanged under write-through. The shared inputs have no effect on either.
- R4: Under write-back, a write hit (`cpu_op`=3) on an exclusive-clean line makes it modified with no bus request, and a modified line stays modified. Under write-through, a write hit changes no state.
- R5: Under write-back, a write hit on a shared-clean line raises `sinv_req`, and the line becomes modified only when the request completes.
- R6: A snoop hit on a valid line makes it shared-clean (`snp_mod`=0) or invalid (`snp_mod`=1). If the line is modified, `cb_req` is raised first and the new state is written only when the copyback completes.
- R7: Under write-back, a processor invalidate (`cpu_op`=5) that hits a shared-clean or exclusive-clean line makes it modified at once.
- R8: A flush (`cpu_op`=6) that hits a modified line raises `cb_req`. When the copyback completes, the line becomes exclusive-clean in the four-state write-back case and shared-clean otherwise. A flush of any other line has no effect.
- R9: A locked read hit (`cpu_op`=4) on a shared-clean line, in the four-state model under write-back, raises `sinv_req`, and the line becomes exclusive-clean on completion. In every other case the locked read changes nothing.
- R10: An invalidate command or cache-inhibited hit (`cpu_op`=7) makes the hit line invalid at once, with no bus request, under every model and policy.
- R11: While a request is pending, exactly one of `cb_req`/`sinv_req` is high, `req_idx` is stable, the line keeps its old state, and both ready outputs are low. The new state is written in the cycle `bus_done` is high.
- R12: When `snp_valid` and `cpu_valid` are high in the same cycle, the snoop is applied and the processor operation is not accepted (`cpu_ready` low).
- R13: A hit-type processor operation with `cpu_hit` low, or a snoop with `snp_hit` low, leaves the line state unchanged and raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| three_state | input | 1 | 1 selects the three-state model |
| write_thru | input | 1 | 1 selects the write-through policy |
| cpu_valid | input | 1 | Processor operation present |
| cpu_op | input | 3 | Processor operation code |
| cpu_idx | input | IDXW | Line index of processor operation |
| cpu_hit | input | 1 | Tag hit for processor operation |
| shd | input | 1 | Shared status seen during fill |
| shd_late | input | 1 | Late shared status seen during fill |
| cpu_ready | output | 1 | Processor operation accepted this cycle |
| snp_valid | input | 1 | Snoop present |
| snp_mod | input | 1 | Snoop is a write or read-with-intent-to-modify |
| snp_idx | input | IDXW | Line index of snoop |
| snp_hit | input | 1 | Tag hit for snoop |
| snp_ready | output | 1 | Snoop accepted this cycle |
| cb_req | output | 1 | Copyback requested |
| sinv_req | output | 1 | System invalidate requested |
| req_idx | output | IDXW | Line index of pending request |
| bus_done | input | 1 | Pending bus action completed |
| look_idx | input | IDXW | Lookup index |
| look_state | output | 2 | Stored state of the looked-up line |

## Verification
The bench builds the block with `LINES`=8, so every index is cheap to prepare and the whole array can be read back after reset. With this small size the bench can sweep every combination of model, policy, starting state and operation. For read fills it also covers each shared-input pattern. Every transition, including both deferred bus-action paths, is checked against a table computed in the bench. Directed cases add a simultaneous snoop and processor operation, and operations whose hit flag is low.

// File: rtl/coh_pkg.sv
package coh_pkg;
   typedef enum logic [1:0] {
      ST_INV = 2'b00,
      ST_SHR = 2'b01,
      ST_EXC = 2'b10,
      ST_MOD = 2'b11
   } line_st_e;

   typedef enum logic [2:0] {
      OP_FILL_RD    = 3'd0,
      OP_FILL_WR    = 3'd1,
      OP_FILL_RWITM = 3'd2,
      OP_WR_HIT     = 3'd3,
      OP_LOCK_RD    = 3'd4,
      OP_PINV       = 3'd5,
      OP_FLUSH      = 3'd6,
      OP_INVCMD     = 3'd7
   } cpu_op_e;

   typedef enum logic [1:0] {
      ACT_NONE = 2'd0,
      ACT_CB   = 2'd1,
      ACT_SINV = 2'd2
   } bus_act_e;

   typedef struct packed {
      logic     wr;
      line_st_e nxt;
      bus_act_e act;
   } upd_t;
endpackage

// File: rtl/coh_state_array.sv
module coh_state_array
   import coh_pkg::*;
#(
   parameter int LINES = 64,
   parameter int IDXW  = $clog2(LINES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [IDXW-1:0] widx,
   input  line_st_e        wst,
   input  logic [IDXW-1:0] ridx_a,
   output line_st_e        rst_a,
   input  logic [IDXW-1:0] ridx_b,
   output line_st_e        rst_b
);
   line_st_e mem [LINES];

   generate
      if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
         $error("coh_state_array: LINES must be a power of two, at least 2");
      end
      if (IDXW != $clog2(LINES)) begin : g_bad_idxw
         $error("coh_state_array: IDXW does not match LINES");
      end
      for (genvar g = 0; g < LINES; g++) begin : g_line
         line_st_e st_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               st_q <= ST_INV;
            else if (we && widx == IDXW'(g))
               st_q <= wst;
         end
         assign mem[g] = st_q;
      end
   endgenerate

   assign rst_a = mem[ridx_a];
   assign rst_b = mem[ridx_b];

   // R11
   no_x_write_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> !$isunknown(widx));
endmodule

// File: rtl/coh_next_state.sv
module coh_next_state
   import coh_pkg::*;
#(
   parameter bit FOUR_STATE_EN = 1'b1
) (
   input  logic     is_snp,
   input  logic [2:0] op,
   input  logic     hit,
   input  logic     shd_any,
   input  logic     snp_mod,
   input  line_st_e cur,
   input  logic     three_state,
   input  logic     write_thru,
   output upd_t     upd
);
   logic m3;
   logic live;

   assign m3   = three_state | ~FOUR_STATE_EN;
   assign live = hit && (cur != ST_INV);

   always_comb begin
      upd.wr  = 1'b0;
      upd.nxt = cur;
      upd.act = ACT_NONE;
      if (is_snp) begin
         if (live) begin
            upd.wr  = 1'b1;
            upd.nxt = snp_mod ? ST_INV : ST_SHR;
            upd.act = (cur == ST_MOD) ? ACT_CB : ACT_NONE;
         end
      end else begin
         unique case (cpu_op_e'(op))
            OP_FILL_RD: begin
               upd.wr  = 1'b1;
               upd.nxt = (shd_any || m3 || write_thru) ? ST_SHR : ST_EXC;
            end
            OP_FILL_WR: begin
               if (!write_thru) begin
                  upd.wr  = 1'b1;
                  upd.nxt = ST_MOD;
               end
            end
            OP_FILL_RWITM: begin
               upd.wr  = 1'b1;
               upd.nxt = ST_MOD;
            end
            OP_WR_HIT: begin
               if (live && !write_thru && cur != ST_MOD) begin
                  upd.wr  = 1'b1;
                  upd.nxt = ST_MOD;
                  upd.act = (cur == ST_SHR) ? ACT_SINV : ACT_NONE;
               end
            end
            OP_LOCK_RD: begin
               if (live && cur == ST_SHR && !write_thru && !m3) begin
                  upd.wr  = 1'b1;
                  upd.nxt = ST_EXC;
                  upd.act = ACT_SINV;
               end
            end
            OP_PINV: begin
               if (live && !write_thru && (cur == ST_SHR || cur == ST_EXC)) begin
                  upd.wr  = 1'b1;
                  upd.nxt = ST_MOD;
               end
            end
            OP_FLUSH: begin
               if (live && cur == ST_MOD) begin
                  upd.wr  = 1'b1;
                  upd.nxt = (m3 || write_thru) ? ST_SHR : ST_EXC;
                  upd.act = ACT_CB;
               end
            end
            OP_INVCMD: begin
               if (live) begin
                  upd.wr  = 1'b1;
                  upd.nxt = ST_INV;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/coh_pend_ctrl.sv
module coh_pend_ctrl
   import coh_pkg::*;
#(
   parameter int IDXW = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  bus_act_e        start_act,
   input  logic [IDXW-1:0] start_idx,
   input  line_st_e        start_st,
   input  logic            bus_done,
   output logic            busy,
   output logic            cb_req,
   output logic            sinv_req,
   output logic [IDXW-1:0] req_idx,
   output logic            commit,
   output line_st_e        commit_st
);
   bus_act_e        act_q;
   logic [IDXW-1:0] idx_q;
   line_st_e        st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= ACT_NONE;
         idx_q <= '0;
         st_q  <= ST_INV;
      end else if (start) begin
         act_q <= start_act;
         idx_q <= start_idx;
         st_q  <= start_st;
      end else if (commit) begin
         act_q <= ACT_NONE;
      end
   end

   assign busy      = (act_q != ACT_NONE);
   assign cb_req    = (act_q == ACT_CB);
   assign sinv_req  = (act_q == ACT_SINV);
   assign req_idx   = idx_q;
   assign commit    = busy && bus_done;
   assign commit_st = st_q;

   // R11
   one_req_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cb_req, sinv_req}));

   // R11
   req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((cb_req || sinv_req) && !bus_done) |=>
         ((cb_req || sinv_req) && $stable(req_idx) && $stable(cb_req)));

   // R11
   no_restart_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !start);
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
   import coh_pkg::*;
#(
   parameter int LINES         = 64,
   parameter bit FOUR_STATE_EN = 1'b1,
   localparam int IDXW         = $clog2(LINES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            three_state,
   input  logic            write_thru,
   input  logic            cpu_valid,
   input  logic [2:0]      cpu_op,
   input  logic [IDXW-1:0] cpu_idx,
   input  logic            cpu_hit,
   input  logic            shd,
   input  logic            shd_late,
   output logic            cpu_ready,
   input  logic            snp_valid,
   input  logic            snp_mod,
   input  logic [IDXW-1:0] snp_idx,
   input  logic            snp_hit,
   output logic            snp_ready,
   output logic            cb_req,
   output logic            sinv_req,
   output logic [IDXW-1:0] req_idx,
   input  logic            bus_done,
   input  logic [IDXW-1:0] look_idx,
   output logic [1:0]      look_state
);
   logic            busy;
   logic            snp_take;
   logic            cpu_take;
   logic            take;
   logic [IDXW-1:0] op_idx;
   line_st_e        cur_st;
   line_st_e        look_st;
   upd_t            upd;
   logic            pend_start;
   logic            commit;
   line_st_e        commit_st;
   logic            arr_we;
   logic [IDXW-1:0] arr_widx;
   line_st_e        arr_wst;

   assign snp_ready = ~busy;
   assign cpu_ready = ~busy & ~snp_valid;
   assign snp_take  = snp_valid & snp_ready;
   assign cpu_take  = cpu_valid & cpu_ready;
   assign take      = snp_take | cpu_take;
   assign op_idx    = snp_take ? snp_idx : cpu_idx;

   coh_next_state #(
      .FOUR_STATE_EN(FOUR_STATE_EN)
   ) u_next (
      .is_snp     (snp_take),
      .op         (cpu_op),
      .hit        (snp_take ? snp_hit : cpu_hit),
      .shd_any    (shd | shd_late),
      .snp_mod    (snp_mod),
      .cur        (cur_st),
      .three_state(three_state),
      .write_thru (write_thru),
      .upd        (upd)
   );

   assign pend_start = take && upd.wr && (upd.act != ACT_NONE);

   coh_pend_ctrl #(
      .IDXW(IDXW)
   ) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (pend_start),
      .start_act(upd.act),
      .start_idx(op_idx),
      .start_st (upd.nxt),
      .bus_done (bus_done),
      .busy     (busy),
      .cb_req   (cb_req),
      .sinv_req (sinv_req),
      .req_idx  (req_idx),
      .commit   (commit),
      .commit_st(commit_st)
   );

   always_comb begin
      if (commit) begin
         arr_we   = 1'b1;
         arr_widx = req_idx;
         arr_wst  = commit_st;
      end else begin
         arr_we   = take && upd.wr && (upd.act == ACT_NONE);
         arr_widx = op_idx;
         arr_wst  = upd.nxt;
      end
   end

   coh_state_array #(
      .LINES(LINES),
      .IDXW (IDXW)
   ) u_arr (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (arr_we),
      .widx  (arr_widx),
      .wst   (arr_wst),
      .ridx_a(op_idx),
      .rst_a (cur_st),
      .ridx_b(look_idx),
      .rst_b (look_st)
   );

   assign look_state = look_st;

   // R2
   no_excl_three_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_we && !commit && three_state) |-> (arr_wst != ST_EXC));

   // R11
   frozen_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((cb_req || sinv_req) && !bus_done) |-> !arr_we);

   // R12
   snoop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && cpu_valid && !busy && arr_we) |-> (arr_widx == snp_idx));

   // R4
   silent_upgrade_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_take && cpu_op == 3'd3 && cur_st == ST_EXC) |=> !(cb_req || sinv_req));
endmodule

// File: tb/test_coh_line_ctrl.sv
`timescale 1ns/1ps
module test_coh_line_ctrl;
   localparam int LINES = 8;
   localparam int IW    = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          three_state = 1'b0;
   logic          write_thru = 1'b0;
   logic          cpu_valid = 1'b0;
   logic [2:0]    cpu_op = 3'd0;
   logic [IW-1:0] cpu_idx = '0;
   logic          cpu_hit = 1'b0;
   logic          shd = 1'b0;
   logic          shd_late = 1'b0;
   logic          cpu_ready;
   logic          snp_valid = 1'b0;
   logic          snp_mod = 1'b0;
   logic [IW-1:0] snp_idx = '0;
   logic          snp_hit = 1'b0;
   logic          snp_ready;
   logic          cb_req;
   logic          sinv_req;
   logic [IW-1:0] req_idx;
   logic          bus_done = 1'b0;
   logic [IW-1:0] look_idx = '0;
   logic [1:0]    look_state;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   coh_line_ctrl #(.LINES(LINES)) i_coh_line_ctrl (
      .clk(clk), .rst_n(rst_n), .three_state(three_state), .write_thru(write_thru),
      .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_idx(cpu_idx), .cpu_hit(cpu_hit),
      .shd(shd), .shd_late(shd_late), .cpu_ready(cpu_ready),
      .snp_valid(snp_valid), .snp_mod(snp_mod), .snp_idx(snp_idx), .snp_hit(snp_hit),
      .snp_ready(snp_ready), .cb_req(cb_req), .sinv_req(sinv_req), .req_idx(req_idx),
      .bus_done(bus_done), .look_idx(look_idx), .look_state(look_state)
   );

   task automatic chk(input string rq, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   task automatic peek(input logic [IW-1:0] i, output logic [1:0] s);
      look_idx = i;
      #0.1;
      s = look_state;
   endtask

   task automatic cpu_issue(input logic [2:0] op, input logic [IW-1:0] idx,
                            input bit hit, input bit s0, input bit s1);
      @(negedge clk);
      cpu_valid = 1'b1; cpu_op = op; cpu_idx = idx; cpu_hit = hit;
      shd = s0; shd_late = s1;
      @(negedge clk);
      cpu_valid = 1'b0; shd = 1'b0; shd_late = 1'b0;
   endtask

   task automatic snp_issue(input bit md, input logic [IW-1:0] idx, input bit hit);
      @(negedge clk);
      snp_valid = 1'b1; snp_mod = md; snp_idx = idx; snp_hit = hit;
      @(negedge clk);
      snp_valid = 1'b0;
   endtask

   // places a line in state s using four-state write-back operations
   task automatic set_state(input logic [IW-1:0] idx, input int s);
      @(negedge clk);
      three_state = 1'b0; write_thru = 1'b0;
      case (s)
         0: cpu_issue(3'd7, idx, 1'b1, 1'b0, 1'b0);
         1: cpu_issue(3'd0, idx, 1'b0, 1'b1, 1'b0);
         2: cpu_issue(3'd0, idx, 1'b0, 1'b0, 1'b0);
         default: cpu_issue(3'd2, idx, 1'b0, 1'b0, 1'b0);
      endcase
   endtask

   // expected {act, next}: act 0 none, 1 copyback, 2 system invalidate
   function automatic int expect_of(input bit snp, input int op, input bit md,
                                    input int st, input bit sh, input bit m3, input bit wt);
      int nxt = st;
      int act = 0;
      if (snp) begin
         if (st != 0) begin
            nxt = md ? 0 : 1;
            act = (st == 3) ? 1 : 0;
         end
      end else begin
         case (op)
            0: nxt = (sh || m3 || wt) ? 1 : 2;
            1: if (!wt) nxt = 3;
            2: nxt = 3;
            3: if (!wt && st != 0) begin
                  nxt = 3;
                  if (st == 1) act = 2;
               end
            4: if (st == 1 && !wt && !m3) begin nxt = 2; act = 2; end
            5: if (!wt && (st == 1 || st == 2)) nxt = 3;
            6: if (st == 3) begin act = 1; nxt = (m3 || wt) ? 1 : 2; end
            default: nxt = 0;
         endcase
      end
      return act * 4 + nxt;
   endfunction

   function automatic string tag_of(input bit snp, input int op, input int st, input bit wt);
      if (snp) return "R6";
      case (op)
         0: return "R2";
         1, 2: return "R3";
         3: return (st == 1 && !wt) ? "R5" : "R4";
         4: return "R9";
         5: return "R7";
         6: return "R8";
         default: return "R10";
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [1:0] s;
      logic [1:0] s2;
      repeat (3) @(negedge clk);
      // R1: reset state
      for (int i = 0; i < LINES; i++) begin
         peek(IW'(i), s);
         chk("R1", s, 0, "line state after reset");
      end
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", cb_req, 0, "cb_req after reset");
      chk("R1", sinv_req, 0, "sinv_req after reset");

      // sweep: model x policy x start state x operation x shared pattern
      for (int m3 = 0; m3 < 2; m3++)
      for (int wt = 0; wt < 2; wt++)
      for (int st = 0; st < 4; st++)
      for (int opi = 0; opi < 10; opi++)
      for (int sv = 0; sv < 3; sv++) begin
         logic [IW-1:0] idx;
         int e, enx, eact;
         bit snp;
         string tg;
         if (opi != 0 && sv != 0) continue;
         idx = IW'(st + opi + sv);
         snp = (opi >= 8);
         set_state(idx, st);
         peek(idx, s);
         chk("R1", s, st, "setup state");
         @(negedge clk);
         three_state = m3[0]; write_thru = wt[0];
         e = expect_of(snp, opi, opi == 9, st, sv != 0, m3[0], wt[0]);
         enx = e % 4; eact = e / 4;
         tg = tag_of(snp, opi, st, wt[0]);
         if (snp) snp_issue(opi == 9, idx, 1'b1);
         else     cpu_issue(3'(opi), idx, 1'b1, sv == 1, sv == 2);
         if (eact == 0) begin
            peek(idx, s);
            chk(tg, s, enx, "next state");
            chk(tg, {cb_req, sinv_req}, 0, "no bus request");
         end else begin
            chk(tg, cb_req, eact == 1, "cb_req raised");
            chk(tg, sinv_req, eact == 2, "sinv_req raised");
            chk("R11", req_idx, idx, "req_idx");
            peek(idx, s);
            chk("R11", s, st, "state held before done");
            chk("R11", {cpu_ready, snp_ready}, 0, "not ready while pending");
            @(negedge clk);
            chk("R11", {cb_req, sinv_req}, eact == 1 ? 2 : 1, "request held");
            peek(idx, s);
            chk("R11", s, st, "state still held");
            bus_done = 1'b1;
            @(negedge clk);
            bus_done = 1'b0;
            peek(idx, s);
            chk(tg, s, enx, "state after done");
            chk("R11", {cb_req, sinv_req}, 0, "request cleared");
         end
      end

      // R13: hit flag low is ignored
      set_state(3'd1, 1);
      cpu_issue(3'd3, 3'd1, 1'b0, 1'b0, 1'b0);
      peek(3'd1, s);
      chk("R13", s, 1, "write hit with hit low");
      chk("R13", {cb_req, sinv_req}, 0, "no request on missed write hit");
      set_state(3'd2, 3);
      snp_issue(1'b1, 3'd2, 1'b0);
      peek(3'd2, s);
      chk("R13", s, 3, "snoop with hit low");
      chk("R13", cb_req, 0, "no copyback on missed snoop");
      cpu_issue(3'd7, 3'd2, 1'b0, 1'b0, 1'b0);
      peek(3'd2, s);
      chk("R13", s, 3, "invalidate command with hit low");

      // R12: snoop served ahead of processor operation
      set_state(3'd4, 1);
      set_state(3'd5, 2);
      @(negedge clk);
      snp_valid = 1'b1; snp_mod = 1'b1; snp_idx = 3'd5; snp_hit = 1'b1;
      cpu_valid = 1'b1; cpu_op = 3'd7; cpu_idx = 3'd4; cpu_hit = 1'b1;
      #0.1;
      chk("R12", cpu_ready, 0, "cpu_ready with snoop present");
      chk("R12", snp_ready, 1, "snp_ready with snoop present");
      @(negedge clk);
      snp_valid = 1'b0;
      peek(3'd5, s);
      peek(3'd4, s2);
      chk("R12", s, 0, "snooped line invalidated");
      chk("R12", s2, 1, "processor line untouched");
      #0.1;
      chk("R12", cpu_ready, 1, "cpu_ready once snoop gone");
      @(negedge clk);
      cpu_valid = 1'b0;
      peek(3'd4, s2);
      chk("R12", s2, 0, "processor op applied next cycle");

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule